// File: doc/BRIEF.md
# Serialized Interrupt Host Controller

This block is the host end of a single-wire serialized interrupt bus. One clock of the block is one state on the wire. A transfer cycle has three parts. First comes a six-state start frame. Then come a parameterised number of three-state data frames, 19 by default. Last comes a stop frame. In the first state of each data frame the block samples the wire and stores the level in a shadow vector. When the stop frame ends, the whole vector moves to the interrupt outputs in one step.

The length of the low pulse in the stop frame tells every slave which mode the next cycle runs in. In continuous mode the host starts each cycle itself after a programmable number of idle states. In quiet mode the host leaves the wire released. When a slave pulls the wire low for one state, the host drives the three remaining low states of the start frame, so the slave does not have to time them. The mode request is a plain input. It is sampled once per cycle, in the first state of the stop frame.

Top module: `sirq_host_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, `irq_o` is all zeros and the wire is released (`sirq_oe_o`=0). The first cycle runs in continuous mode, so the host begins a start frame after the idle count.
- R2: In continuous mode the wire stays released for exactly max(`idle_cnt_i`, 1) states between the last state of a stop frame and the first state of the next start frame. An idle count of 0 behaves as 1.
- R3: A start frame that the host begins is driven low for 4 states, then driven high for 1 state, then released for 1 state. That makes 6 states in all.
- R4: In quiet mode the host does not drive the wire while idle. When a slave holds the wire low for one state, the host drives low for the next 3 states, then high for 1 state, then releases for 1 state.
- R5: After the start frame come NUM_FRAMES data frames of 3 states each. Frame k, counted from 0 right after the start frame, is sampled in its first state and is reported on `irq_o[k]`.
- R6: A low level sampled in a frame sets its `irq_o` bit to 1. A high level sets it to 0.
- R7: `irq_o` holds its previous value during the whole transfer cycle. It takes the new frame results at the clock edge that ends the stop frame.
- R8: A stop frame has one released state, then a host-driven low pulse, then 1 state driven high, then 1 released state. The pulse is 2 states long when quiet mode is requested and 3 states long when continuous mode is requested.
- R9: `quiet_req_i` is sampled only in the first (released) state of the stop frame. A change at any later state does not alter the pulse length or the next mode.
- R10: After a 2-state stop pulse the block is in quiet mode and never starts a cycle itself. After a 3-state pulse it is in continuous mode.
- R11: The host never drives the wire during data frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock; one period is one wire state |
| rst_n | input | 1 | Synchronous active-low reset |
| quiet_req_i | input | 1 | 1 requests quiet mode for the next cycle, 0 requests continuous |
| idle_cnt_i | input | IDLE_W | Idle states between cycles in continuous mode (0 acts as 1) |
| sirq_i | input | 1 | Level currently seen on the interrupt wire |
| sirq_oe_o | output | 1 | 1 when the host drives the wire |
| sirq_o | output | 1 | Value driven on the wire when `sirq_oe_o` is 1 |
| irq_o | output | NUM_FRAMES | Decoded interrupt vector, bit k from data frame k, 1 = asserted |

## Verification
The decoder is tried with several slave patterns: all frames high, all frames low, alternating bits, single bits at either end, and irregular mixes. These separate a frame-index offset, a swapped bit order, an inverted level and a stuck bit. Cycles begun by the host and cycles begun by a slave run with the same patterns, which shows that both start paths line up the data frames at the same offset. Stop pulses are measured while the mode request alternates, and also when the request flips after the stop frame has begun. Gaps are measured for several idle counts, including 0 and 1. Together these separate a wrong latch point for the mode request from a wrong pulse length or a wrong idle-count limit.

// File: rtl/sirq_host_pkg.sv
// Shared types for the serialized interrupt host controller.
// Assumes one wire state per clock cycle.
package sirq_host_pkg;

    // Transfer-cycle phase seen by the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } sirq_phase_e;

    // What the host does with the wire in the current state.
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_LOW  = 2'd1,
        DRV_HIGH = 2'd2
    } sirq_drive_e;

    // Last step index of a start frame (6 states: 0..5).
    localparam int unsigned START_LAST = 5;
    // Last step that the host holds low in a start frame.
    localparam int unsigned START_LOW_LAST = 3;
    // States per data frame.
    localparam int unsigned FRAME_STATES = 3;
    // Stop-pulse lengths that encode the next mode.
    localparam int unsigned STOP_PULSE_QUIET = 2;
    localparam int unsigned STOP_PULSE_CONT  = 3;

endpackage

// File: rtl/sirq_host_seq.sv
// Sequencer: walks idle, start, data and stop phases one state per clock.
// In continuous mode it starts a cycle after the idle count. In quiet mode it
// waits for a slave to pull the wire low and then joins the start frame at step 1.
// It latches the mode request in the first stop state and applies it when the
// cycle ends. Assumes sirq_i is already synchronous to clk.
module sirq_host_seq
    import sirq_host_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 19,
    parameter int unsigned IDLE_W     = 8,
    localparam int unsigned FIDX_W    = $clog2(NUM_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              quiet_req_i,
    input  logic [IDLE_W-1:0] idle_cnt_i,
    input  logic              sirq_i,
    output sirq_phase_e       phase_o,
    output logic [2:0]        step_o,
    output logic              quiet_nxt_o,
    output logic              quiet_cur_o,
    output logic              sample_en_o,
    output logic [FIDX_W-1:0] sample_idx_o,
    output logic              commit_o
);

    localparam logic [2:0]        START_END = 3'(START_LAST);
    localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(NUM_FRAMES - 1);
    localparam logic [1:0]        SUB_LAST  = 2'(FRAME_STATES - 1);

    sirq_phase_e       phase_q;
    logic [2:0]        step_q;
    logic [FIDX_W-1:0] fidx_q;
    logic [1:0]        sub_q;
    logic [IDLE_W-1:0] wait_q;
    logic              quiet_cur_q;
    logic              quiet_nxt_q;

    logic [IDLE_W-1:0] idle_limit;
    logic [2:0]        stop_end;
    logic              idle_done;

    // Clamp the idle count to at least one state; pick the last stop step.
    always_comb begin
        idle_limit = (idle_cnt_i == '0) ? IDLE_W'(1) : idle_cnt_i;
        idle_done  = (wait_q >= (idle_limit - IDLE_W'(1)));
        stop_end   = quiet_nxt_q ? 3'(STOP_PULSE_QUIET + 2) : 3'(STOP_PULSE_CONT + 2);
    end

    // Phase, step, frame and idle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            step_q      <= '0;
            fidx_q      <= '0;
            sub_q       <= '0;
            wait_q      <= '0;
            quiet_cur_q <= 1'b0;
            quiet_nxt_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (quiet_cur_q) begin
                        if (!sirq_i) begin
                            phase_q <= PH_START;
                            step_q  <= 3'd1;
                        end
                    end else if (idle_done) begin
                        phase_q <= PH_START;
                        step_q  <= 3'd0;
                        wait_q  <= '0;
                    end else begin
                        wait_q <= wait_q + IDLE_W'(1);
                    end
                end
                PH_START: begin
                    if (step_q == START_END) begin
                        phase_q <= PH_DATA;
                        fidx_q  <= '0;
                        sub_q   <= '0;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                PH_DATA: begin
                    if (sub_q == SUB_LAST) begin
                        sub_q <= '0;
                        if (fidx_q == FIDX_LAST) begin
                            phase_q <= PH_STOP;
                            step_q  <= 3'd0;
                        end else begin
                            fidx_q <= fidx_q + FIDX_W'(1);
                        end
                    end else begin
                        sub_q <= sub_q + 2'd1;
                    end
                end
                PH_STOP: begin
                    if (step_q == 3'd0) begin
                        quiet_nxt_q <= quiet_req_i;
                    end
                    if (step_q == stop_end) begin
                        phase_q     <= PH_IDLE;
                        step_q      <= '0;
                        wait_q      <= '0;
                        quiet_cur_q <= quiet_nxt_q;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Status strobes for the capture stage.
    always_comb begin
        sample_en_o  = (phase_q == PH_DATA) && (sub_q == 2'd0);
        sample_idx_o = fidx_q;
        commit_o     = (phase_q == PH_STOP) && (step_q == stop_end);
    end

    assign phase_o     = phase_q;
    assign step_o      = step_q;
    assign quiet_nxt_o = quiet_nxt_q;
    assign quiet_cur_o = quiet_cur_q;

endmodule

// File: rtl/sirq_host_drive.sv
// Wire driver: decodes phase and step into drive enable and value.
// Start frame: low through step 3, high at step 4, released at step 5.
// Stop frame: released at step 0, low for the mode-coded pulse, high for one
// state, then released. Purely combinational over registered state.
module sirq_host_drive
    import sirq_host_pkg::*;
(
    input  sirq_phase_e phase_i,
    input  logic [2:0]  step_i,
    input  logic        quiet_nxt_i,
    output logic        oe_o,
    output logic        val_o
);

    sirq_drive_e drv;
    logic [2:0]  plen;

    // Choose the host action for the current state.
    always_comb begin
        plen = quiet_nxt_i ? 3'(STOP_PULSE_QUIET) : 3'(STOP_PULSE_CONT);
        drv  = DRV_OFF;
        case (phase_i)
            PH_START: begin
                if (step_i <= 3'(START_LOW_LAST)) drv = DRV_LOW;
                else if (step_i == 3'(START_LOW_LAST + 1)) drv = DRV_HIGH;
            end
            PH_STOP: begin
                if ((step_i >= 3'd1) && (step_i <= plen)) drv = DRV_LOW;
                else if (step_i == plen + 3'd1) drv = DRV_HIGH;
            end
            default: drv = DRV_OFF;
        endcase
    end

    // Map the action onto the pad controls.
    always_comb begin
        oe_o  = (drv != DRV_OFF);
        val_o = (drv == DRV_HIGH);
    end

endmodule

// File: rtl/sirq_host_capture.sv
// Capture stage: stores the inverted wire level per frame in a shadow
// vector and moves the vector to the output on the commit strobe, so that
// the outputs change only once per transfer cycle.
module sirq_host_capture #(
    parameter int unsigned NUM_FRAMES = 19,
    localparam int unsigned FIDX_W    = $clog2(NUM_FRAMES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sirq_i,
    input  logic                  sample_en_i,
    input  logic [FIDX_W-1:0]     sample_idx_i,
    input  logic                  commit_i,
    output logic [NUM_FRAMES-1:0] irq_o
);

    logic [NUM_FRAMES-1:0] shadow_q;
    logic [NUM_FRAMES-1:0] irq_q;

    for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_frame
        // One shadow bit per frame, low level means asserted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[k] <= 1'b0;
            end else if (sample_en_i && (sample_idx_i == FIDX_W'(k))) begin
                shadow_q[k] <= ~sirq_i;
            end
        end
    end

    // Publish the whole vector at the end of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else if (commit_i) begin
            irq_q <= shadow_q;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sirq_host_ctrl.sv
// Top of the serialized interrupt host controller. It ties the sequencer,
// the wire driver and the capture stage together. The pad is modelled as an
// enable/value pair plus the observed level. An external pull-up keeps the
// wire high when nobody drives it.
module sirq_host_ctrl
    import sirq_host_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 19,
    parameter int unsigned IDLE_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  quiet_req_i,
    input  logic [IDLE_W-1:0]     idle_cnt_i,
    input  logic                  sirq_i,
    output logic                  sirq_oe_o,
    output logic                  sirq_o,
    output logic [NUM_FRAMES-1:0] irq_o
);

    localparam int unsigned FIDX_W = $clog2(NUM_FRAMES);

    sirq_phase_e       phase;
    logic [2:0]        step;
    logic              quiet_nxt;
    logic              quiet_cur;
    logic              sample_en;
    logic [FIDX_W-1:0] sample_idx;
    logic              commit;
    logic              in_idle;

    sirq_host_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .IDLE_W     (IDLE_W)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .quiet_req_i  (quiet_req_i),
        .idle_cnt_i   (idle_cnt_i),
        .sirq_i       (sirq_i),
        .phase_o      (phase),
        .step_o       (step),
        .quiet_nxt_o  (quiet_nxt),
        .quiet_cur_o  (quiet_cur),
        .sample_en_o  (sample_en),
        .sample_idx_o (sample_idx),
        .commit_o     (commit)
    );

    sirq_host_drive drive_i (
        .phase_i     (phase),
        .step_i      (step),
        .quiet_nxt_i (quiet_nxt),
        .oe_o        (sirq_oe_o),
        .val_o       (sirq_o)
    );

    sirq_host_capture #(
        .NUM_FRAMES (NUM_FRAMES)
    ) capture_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sirq_i       (sirq_i),
        .sample_en_i  (sample_en),
        .sample_idx_i (sample_idx),
        .commit_i     (commit),
        .irq_o        (irq_o)
    );

    // Idle flag for the bound checker.
    assign in_idle = (phase == PH_IDLE);

endmodule

// File: rtl/sirq_host_ctrl_chk.sv
// Checker bound to the host controller. It watches the pad controls, the
// interrupt vector and the idle/mode state over time.
module sirq_host_ctrl_chk #(
    parameter int unsigned NUM_FRAMES = 19
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sirq_i,
    input logic                  sirq_oe_o,
    input logic                  sirq_o,
    input logic [NUM_FRAMES-1:0] irq_o,
    input logic                  quiet_mode,
    input logic                  idle_phase
);

    logic [2:0] low_run;

    // Count consecutive host-driven low states, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) low_run <= '0;
        else if (sirq_oe_o && !sirq_o) low_run <= (low_run == 3'd7) ? low_run : low_run + 3'd1;
        else low_run <= '0;
    end

    // R1: reset releases the wire and clears the vector.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!sirq_oe_o && irq_o == '0));

    // R3 / R8: a driven-high state always follows a driven-low state.
    a_r3_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sirq_oe_o && sirq_o) |-> $past(sirq_oe_o && !sirq_o));

    // R8: the wire is released right after the recovery state.
    a_r8_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sirq_oe_o && sirq_o) |-> !sirq_oe_o);

    // R3: no host low pulse is longer than the 4-state start pulse.
    a_r3_low_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 3'd4);

    // R7: the vector changes only after a recovery state and a release state.
    a_r7_commit_at_stop_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(irq_o)) |-> ($past(!sirq_oe_o) && $past(sirq_oe_o && sirq_o, 2)));

    // R10: idle in quiet mode with the wire high means the host stays off.
    a_r10_quiet_no_host_start: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_phase && quiet_mode && sirq_i) |=> !sirq_oe_o);

endmodule

bind sirq_host_ctrl sirq_host_ctrl_chk #(.NUM_FRAMES(NUM_FRAMES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sirq_i     (sirq_i),
    .sirq_oe_o  (sirq_oe_o),
    .sirq_o     (sirq_o),
    .irq_o      (irq_o),
    .quiet_mode (quiet_cur),
    .idle_phase (in_idle)
);

// File: tb/sirq_host_ctrl_tb_top.sv
// Bench for the serialized interrupt host controller: a vector table of
// slave patterns and mode requests, then directed reset tests.
module sirq_host_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NF = 19;
    localparam int NVEC = 10;

    // Row layout: {pattern[18:0], quiet request, slave start, late flip, idle[3:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {19'h00000, 1'b0, 1'b0, 1'b0, 4'd3},
        {19'h7FFFF, 1'b0, 1'b0, 1'b0, 4'd0},
        {19'h5A5A5, 1'b1, 1'b0, 1'b0, 4'd2},
        {19'h12345, 1'b1, 1'b1, 1'b0, 4'd0},
        {19'h40001, 1'b0, 1'b1, 1'b0, 4'd0},
        {19'h2AAAA, 1'b0, 1'b0, 1'b0, 4'd5},
        {19'h00001, 1'b0, 1'b0, 1'b1, 4'd1},
        {19'h7FFFE, 1'b1, 1'b0, 1'b0, 4'd4},
        {19'h55555, 1'b1, 1'b1, 1'b1, 4'd0},
        {19'h0AAAA, 1'b0, 1'b1, 1'b0, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          quiet_req = 1'b0;
    logic [7:0]    idle_cnt = 8'd3;
    logic          slv_drv = 1'b0;
    logic          sirq_w;
    logic          sirq_oe;
    logic          sirq_val;
    logic [NF-1:0] irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wire with pull-up: host wins when it drives, else slave can pull low.
    assign sirq_w = sirq_oe ? sirq_val : ~slv_drv;

    sirq_host_ctrl #(.NUM_FRAMES(NF), .IDLE_W(8)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .quiet_req_i (quiet_req),
        .idle_cnt_i  (idle_cnt),
        .sirq_i      (sirq_w),
        .sirq_oe_o   (sirq_oe),
        .sirq_o      (sirq_val),
        .irq_o       (irq)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One transfer cycle, with a slave pattern and its expected results.
    task automatic run_cycle(input logic [NF-1:0] pat, input logic qreq, input logic sstart,
                             input logic late, input logic [3:0] idl, input logic prev_cont);
        int gap;
        int plen;
        int tend;
        int exp_plen;
        int k;
        logic start_ok;
        logic data_ok;
        logic hi_ok;
        logic quiet_ok;
        logic [NF-1:0] prev_irq;
        gap = 0;
        plen = 0;
        start_ok = 1'b1;
        data_ok = 1'b1;
        hi_ok = 1'b0;
        quiet_ok = 1'b1;
        exp_plen = qreq ? 2 : 3;
        tend = qreq ? 68 : 69;
        quiet_req = qreq;
        idle_cnt = 8'(idl);
        prev_irq = irq;
        if (sstart) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (sirq_oe) quiet_ok = 1'b0;
            end
            check(quiet_ok, "R10 quiet idle host drove", longint'(quiet_ok), 1);
            slv_drv = 1'b1;
        end else begin
            while (!(sirq_oe && !sirq_val) && gap < 400) begin
                @(negedge clk);
                gap++;
            end
            if (prev_cont) check(gap == ((idl == 0) ? 1 : int'(idl)), "R2 idle gap", gap, (idl == 0) ? 1 : idl);
        end
        for (int t = 1; t <= tend; t++) begin
            @(negedge clk);
            k = (t - 6) / 3;
            slv_drv = (t >= 6) && (((t - 6) % 3) == 0) && (k < NF) && pat[k];
            if (t == 64 && late) quiet_req = ~qreq;
            if (t <= 3 && !(sirq_oe && !sirq_val)) start_ok = 1'b0;
            if (t == 4 && !(sirq_oe && sirq_val)) start_ok = 1'b0;
            if (t == 5 && sirq_oe) start_ok = 1'b0;
            if (t >= 6 && t <= 62 && sirq_oe) data_ok = 1'b0;
            if (t == 40) check(irq == prev_irq, "R7 vector stable mid-cycle", irq, prev_irq);
            if (t == 63) check(!sirq_oe, "R8 stop idle state", sirq_oe, 0);
            if (t >= 64 && t < tend && sirq_oe && !sirq_val) plen++;
            if (t == 64 + exp_plen && sirq_oe && sirq_val) hi_ok = 1'b1;
        end
        if (sstart) check(start_ok, "R4 slave start completion", start_ok, 1);
        else check(start_ok, "R3 host start shape", start_ok, 1);
        check(data_ok, "R11 released in data frames", data_ok, 1);
        check(plen == exp_plen, late ? "R9 late mode change pulse" : "R8 stop pulse length", plen, exp_plen);
        check(hi_ok, "R8 stop recovery high", hi_ok, 1);
        check(!sirq_oe, "R8 released after stop", sirq_oe, 0);
        check(irq == pat, "R5 R6 decoded vector", irq, pat);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int gap;
        logic prev_cont;
        repeat (4) @(negedge clk);
        check(!sirq_oe && irq == '0, "R1 reset state", {sirq_oe, irq}, 0);
        rst_n = 1'b1;
        prev_cont = 1'b1;

        // Table walk: each row is one complete transfer cycle.
        for (int r = 0; r < NVEC; r++) begin
            run_cycle(VEC[r][25:7], VEC[r][6], VEC[r][5], VEC[r][4], VEC[r][3:0], prev_cont);
            prev_cont = !VEC[r][6];
        end

        // Directed: reset in the middle of a cycle (last row left continuous mode).
        idle_cnt = 8'd2;
        gap = 0;
        while (!(sirq_oe && !sirq_val) && gap < 400) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 2, "R2 gap before reset test", gap, 2);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!sirq_oe && irq == '0, "R1 reset mid-cycle", {sirq_oe, irq}, 0);
        idle_cnt = 8'd3;
        quiet_req = 1'b1;
        rst_n = 1'b1;
        gap = 0;
        while (!(sirq_oe && !sirq_val) && gap < 400) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 3, "R1 continuous after reset", gap, 3);
        repeat (80) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule